// File: doc/BRIEF.md
# Shift-Register-State Observable Mealy Machine

A synchronous five-state Mealy machine with one binary input and two binary outputs. Its state code sits mostly in a two-stage shift register: each clock edge, the second stage takes what the first stage held. The second output is wired straight to the last stage. As a result, a short window of outputs is enough to identify the state the machine was in, which keeps checking experiments on it short.

States 2 and 3 share the same shift-register code. One extra internal bit separates them. The first output is formed from that bit together with the shift-register code. A synchronous reset places the machine in state 1. The present state number is exported as a 3-bit value, but only so that verification can observe it.

Top module: `shiftObsMealy`

## Requirements
- R1: While `rst` is high at a rising edge, the machine enters state 1, with `stateNum` = 1, `z1` = 0 and `z2` = 1 after that edge.
- R2: Each transition follows this next-state table, given as (x=0, x=1): 1→(4,2), 2→(3,2), 3→(4,3), 4→(5,5), 5→(5,1).
- R3: `z1` is a function of the present state only: it is 1 in states 3, 4 and 5 and 0 in states 1 and 2.
- R4: `z2` is a function of the present state only: it is 1 in states 1 and 5 and 0 in states 2, 3 and 4.
- R5: Outside reset, `z2` after an edge is 1 exactly when the state before that edge was 4 or 5. This is the copy from the first stage to the last.
- R6: The triple (`z1` now, `z2` now, `z2` one cycle later) identifies the present state: 010→1, 000→2, 100→3, 101→4, 111→5.
- R7: `stateNum` always lies in the range 1 to 5.
- R8: Reset takes priority over `x`. From any state, a reset edge gives state 1 whatever the value of `x`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| x | input | 1 | Machine input symbol |
| z1 | output | 1 | Primary output |
| z2 | output | 1 | Added output, last shift-register stage |
| stateNum | output | 3 | Present state number 1 to 5, for verification only |

## Verification
The bench drives one input path that takes every one of the ten transitions. The x=0 step out of state 2 catches a design that confuses states 2 and 3: such a design would stay in state 2 or would report the wrong `z1`. For every cycle, the bench rebuilds the state from the output window alone. A stage that fails to copy, or a `z2` tapped from the wrong stage, produces a triple that points to the wrong state. Reset is applied from state 5 with `x` held at 1, where the table would otherwise lead to state 1 by a transition rather than by reset. It is also applied from state 3, where a design that lets `x` win, or that fails to clear the split bit, ends in the wrong state.

// File: rtl/shiftObsPkg.sv
package shiftObsPkg;
  localparam int SR_STAGES = 2;
  localparam int STATE_W   = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_ONE   = 3'd1,
    ST_TWO   = 3'd2,
    ST_THREE = 3'd3,
    ST_FOUR  = 3'd4,
    ST_FIVE  = 3'd5
  } obsState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic feedBit;   // value shifted into the first stage
    logic splitNext; // next value of the 2/3 separating bit
  } ctrlStrobe_t;

  // reset code: first stage 0, last stage 1 (state 1)
  localparam logic [SR_STAGES-1:0] RESET_CODE = SR_STAGES'(1) << (SR_STAGES-1);
endpackage

// File: rtl/shiftObsDatapath.sv
module shiftObsDatapath
  import shiftObsPkg::*;
#(
  parameter int STAGES = SR_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strobe,
  output logic [STAGES-1:0] shCode,
  output logic              splitBit,
  output logic              z1,
  output logic              z2
);
  localparam int LAST = STAGES - 1;
  localparam logic [STAGES-1:0] RST_VAL = SR_STAGES'(RESET_CODE);

  logic [STAGES-1:0] stageQ;
  logic              splitQ;

  always_ff @(posedge clk) begin
    if (rst) stageQ[0] <= RST_VAL[0];
    else     stageQ[0] <= strobe.feedBit;
  end

  genvar gi;
  generate
    for (gi = 1; gi < STAGES; gi++) begin : gCopy
      always_ff @(posedge clk) begin
        if (rst) stageQ[gi] <= RST_VAL[gi];
        else     stageQ[gi] <= stageQ[gi-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) splitQ <= 1'b0;
    else     splitQ <= strobe.splitNext;
  end

  assign shCode   = stageQ;
  assign splitBit = splitQ;
  assign z2       = stageQ[LAST];
  assign z1       = stageQ[0] | splitQ;
endmodule

// File: rtl/shiftObsControl.sv
module shiftObsControl
  import shiftObsPkg::*;
#(
  parameter int STAGES = SR_STAGES
) (
  input  logic               x,
  input  logic [STAGES-1:0]  shCode,
  input  logic               splitBit,
  output ctrlStrobe_t        strobe,
  output logic [STATE_W-1:0] stateNum
);
  obsState_t curState;
  logic firstStage;
  logic lastStage;

  assign firstStage = shCode[0];
  assign lastStage  = shCode[STAGES-1];

  // decode shift-register code plus split bit into a state
  always_comb begin
    unique case ({firstStage, lastStage})
      2'b01:   curState = ST_ONE;
      2'b00:   curState = splitBit ? ST_THREE : ST_TWO;
      2'b10:   curState = ST_FOUR;
      default: curState = ST_FIVE;
    endcase
  end

  // feedback and split-bit logic
  always_comb begin
    strobe = '0;
    unique case (curState)
      ST_ONE:   strobe.feedBit = ~x;
      ST_TWO: begin
        strobe.feedBit   = 1'b0;
        strobe.splitNext = ~x;
      end
      ST_THREE: begin
        strobe.feedBit   = ~x;
        strobe.splitNext = x;
      end
      ST_FOUR:  strobe.feedBit = 1'b1;
      default:  strobe.feedBit = ~x;
    endcase
  end

  assign stateNum = STATE_W'(curState);
endmodule

// File: rtl/shiftObsMealy.sv
module shiftObsMealy
  import shiftObsPkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               x,
  output logic               z1,
  output logic               z2,
  output logic [STATE_W-1:0] stateNum
);
  ctrlStrobe_t          strobe;
  logic [SR_STAGES-1:0] shCode;
  logic                 splitBit;

  shiftObsControl #(.STAGES(SR_STAGES)) u_ctrl (
    .x        (x),
    .shCode   (shCode),
    .splitBit (splitBit),
    .strobe   (strobe),
    .stateNum (stateNum)
  );

  shiftObsDatapath #(.STAGES(SR_STAGES)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .shCode   (shCode),
    .splitBit (splitBit),
    .z1       (z1),
    .z2       (z2)
  );
endmodule

// File: rtl/shiftObsMealyChecker.sv
module shiftObsMealyChecker (
  input logic       clk,
  input logic       rst,
  input logic       x,
  input logic       z1,
  input logic       z2,
  input logic [2:0] stateNum
);
  function automatic logic [2:0] expNext(input logic [2:0] s, input logic xv);
    case (s)
      3'd1:    return xv ? 3'd2 : 3'd4;
      3'd2:    return xv ? 3'd2 : 3'd3;
      3'd3:    return xv ? 3'd3 : 3'd4;
      3'd4:    return 3'd5;
      default: return xv ? 3'd1 : 3'd5;
    endcase
  endfunction

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (stateNum == 3'd1 && !z1 && z2)); // R1

  AST_NEXT_STATE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> stateNum == expNext($past(stateNum), $past(x))); // R2

  AST_Z1_MAP: assert property (@(posedge clk) disable iff (rst)
    z1 == (stateNum >= 3'd3)); // R3

  AST_Z2_MAP: assert property (@(posedge clk) disable iff (rst)
    z2 == (stateNum == 3'd1 || stateNum == 3'd5)); // R4

  AST_STAGE_COPY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> z2 == ($past(stateNum) >= 3'd4)); // R5

  AST_STATE_RANGE: assert property (@(posedge clk) disable iff (rst)
    stateNum >= 3'd1 && stateNum <= 3'd5); // R7
endmodule

bind shiftObsMealy shiftObsMealyChecker u_chk (
  .clk      (clk),
  .rst      (rst),
  .x        (x),
  .z1       (z1),
  .z2       (z2),
  .stateNum (stateNum)
);

// File: tb/shiftObsMealy_bench.sv
module shiftObsMealy_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       x   = 1'b0;
  logic       z1;
  logic       z2;
  logic [2:0] stateNum;

  int vecCount = 0;
  int errCount = 0;
  int refState = 1;
  bit done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  shiftObsMealy u_shiftObsMealy (
    .clk(clk), .rst(rst), .x(x), .z1(z1), .z2(z2), .stateNum(stateNum)
  );

  function automatic int refNext(input int s, input bit xv);
    case (s)
      1: return xv ? 2 : 4;
      2: return xv ? 2 : 3;
      3: return xv ? 3 : 4;
      4: return 5;
      default: return xv ? 1 : 5;
    endcase
  endfunction

  function automatic int refZ1(input int s); return (s >= 3) ? 1 : 0; endfunction
  function automatic int refZ2(input int s); return (s == 1 || s == 5) ? 1 : 0; endfunction

  // R6 window decode
  function automatic int windowState(input bit a, input bit b, input bit c);
    case ({a, b, c})
      3'b010: return 1;
      3'b000: return 2;
      3'b100: return 3;
      3'b101: return 4;
      3'b111: return 5;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    vecCount++;
    if (act != exp) begin
      errCount++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkOutputs(input string tag);
    check({tag, " R2 stateNum"}, int'(stateNum), refState);
    check({tag, " R3 z1"}, int'(z1), refZ1(refState));
    check({tag, " R4 z2"}, int'(z2), refZ2(refState));
  endtask

  // apply one input bit, sample after the edge
  task automatic step(input bit xv);
    bit   pz1, pz2;
    int   pState;
    pz1 = z1; pz2 = z2; pState = refState;
    x = xv;
    @(posedge clk); #1;
    refState = refNext(refState, xv);
    checkOutputs("step");
    check("R5 copy", int'(z2), (pState >= 4) ? 1 : 0);
    check("R6 window", windowState(pz1, pz2, z2), pState);
    check("R7 range", (stateNum >= 1 && stateNum <= 5) ? 1 : 0, 1);
  endtask

  task automatic doReset(input bit xv);
    rst = 1'b1; x = xv;
    @(posedge clk); #1;
    rst = 1'b0;
    refState = 1;
    check("R1 reset state", int'(stateNum), 1);
    check("R1 reset z1", int'(z1), 0);
    check("R1 reset z2", int'(z2), 1);
  endtask

  task automatic testReset();
    doReset(1'b0);
  endtask

  task automatic testAllTransitions();
    bit path [10] = '{0, 0, 0, 1, 1, 1, 0, 1, 0, 1};
    doReset(1'b0);
    foreach (path[i]) step(path[i]);
  endtask

  task automatic testResetPriority();
    doReset(1'b0);
    step(1'b0); step(1'b0); // state 5
    check("R8 reached 5", int'(stateNum), 5);
    doReset(1'b1);
    check("R8 from 5 with x=1", int'(stateNum), 1);
    step(1'b1); step(1'b0); // state 3
    check("R8 reached 3", int'(stateNum), 3);
    doReset(1'b1);
    check("R8 from 3 with x=1", int'(stateNum), 1);
    check("R8 z1 after reset", int'(z1), 0);
  endtask

  task automatic testLongPattern();
    logic [7:0] lfsr = 8'hA5;
    doReset(1'b0);
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[0]);
    end
  endtask

  initial begin
    #1;
    @(posedge clk); #1;
    testReset();
    testAllTransitions();
    testResetPriority();
    testLongPattern();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errCount++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
      $finish;
    end
  end
endmodule